// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Flags

This block is a single-clock first-in first-out buffer. Words enter through a write enable and data input and leave through a read enable and data output. Beside full status it reports a half-full level and two programmable threshold flags, almost-full and almost-empty. Both are active low. Their thresholds sit in two offset registers that are loaded through a small register-write port.

A mode input picks one of two read behaviours. In standard mode, the shared status output `head_flag` is an empty indicator, and a read delivers the oldest word on the output one cycle after it is accepted. In fall-through mode, the oldest word is prefetched into an output register with no read request. `head_flag` then means "a valid word is on the output", and `rd_en` consumes that word. The mode is meant to be set while reset is asserted and held afterwards.

Occupancy is tracked in a counter one bit wider than the address. In fall-through mode the prefetched word counts as stored. All flags are registered from the next-cycle occupancy, so they agree with the contents from the first cycle after any access.

Top module: `pflag_fifo`

## Requirements
- R1: In standard mode (`rd_mode`=0), words leave in the order they were written. An accepted read places the oldest word on `rd_data` in the cycle after the read, and `rd_data` holds its value while no read is accepted.
- R2: In standard mode, `head_flag` is 1 exactly when the occupancy is zero.
- R3: In fall-through mode (`rd_mode`=1), `head_flag` is 1 exactly when the occupancy is non-zero. A word written into an empty buffer appears on `rd_data` with `head_flag`=1 in the cycle after the write, with no read request. An accepted read advances `rd_data` to the next word in the cycle after.
- R4: `full` is 1 exactly when the occupancy equals the depth. A write while full is ignored and leaves the contents unchanged.
- R5: A read in standard mode with zero occupancy, or in fall-through mode with `head_flag`=0, is ignored. The output data and the read position are unchanged.
- R6: A read and a write that are both accepted in the same cycle leave the occupancy unchanged.
- R7: `af_n` is 1 when the free space (depth minus occupancy) is greater than the full offset m, and 0 otherwise.
- R8: `ae_n` is 1 when the occupancy is greater than or equal to the empty offset n, and 0 otherwise.
- R9: `hf_n` is 0 when the occupancy is at least depth/2+1, and 1 otherwise.
- R10: A pulse on `cfg_we` loads `cfg_data` into the empty offset n when `cfg_sel`=0, or into the full offset m when `cfg_sel`=1. The flags reflect the new value from the cycle after the write.
- R11: A synchronous reset (`rst`=1) empties the buffer and sets both offsets to 7. After reset, `full`=0, `af_n`=1, `ae_n`=0 and `hf_n`=1; `head_flag` is 1 in standard mode and 0 in fall-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous master reset, active high |
| rd_mode | input | 1 | 0 = standard read, 1 = fall-through read |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read data |
| cfg_we | input | 1 | Offset register write strobe |
| cfg_sel | input | 1 | 0 = empty offset n, 1 = full offset m |
| cfg_data | input | ADDR_W+1 | Offset value to load |
| full | output | 1 | Buffer full |
| head_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| af_n | output | 1 | Almost-full, active low |
| ae_n | output | 1 | Almost-empty, active low |
| hf_n | output | 1 | Half-full, active low |

## Verification
Several corner cases are targeted directly.

- Each flag is checked at the exact occupancies on both sides of its threshold, with default and reprogrammed offsets. This catches an off-by-one compare, such as a strict-versus-inclusive slip in one of the almost flags, which would move a flag edge by one word.
- The bench writes into a full buffer and reads from an empty one, then checks that later data comes out in order. A design that moves a pointer on a refused access would later return a stale or skipped word.
- In fall-through mode, it checks that a lone word appears on the output one cycle after the write. It also checks that a read and a write in the same cycle on a single stored word hand over the new word directly. A design without the bypass would drop `head_flag` for a cycle or lose that word.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

    typedef enum logic {
        RD_STD  = 1'b0,
        RD_FWFT = 1'b1
    } rd_mode_e;

    typedef enum logic {
        OFS_EMPTY = 1'b0,
        OFS_FULL  = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        logic full;
        logic head;
        logic af_n;
        logic ae_n;
        logic hf_n;
    } flag_t;

    localparam int unsigned DEF_OFFSET = 7;

    // Flag vector for a given occupancy and set of thresholds
    function automatic flag_t flags_from(
        input int unsigned occ,
        input int unsigned depth,
        input int unsigned m_ofs,
        input int unsigned n_ofs,
        input logic        is_fwft,
        input logic        head_v
    );
        flag_t f;
        f.full = (occ == depth);
        f.head = is_fwft ? head_v : (occ == 0);
        f.af_n = ((depth - occ) > m_ofs);
        f.ae_n = (occ >= n_ofs);
        f.hf_n = !(occ >= (depth / 2) + 1);
        return f;
    endfunction

endpackage

// File: rtl/pflag_fifo_store.sv
module pflag_fifo_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pflag_fifo_ctrl.sv
module pflag_fifo_ctrl
    import pflag_fifo_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_mode_e          mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W:0]   occ_nxt,
    output logic              head_v_nxt
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned CW    = ADDR_W + 1;
    localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);

    logic [ADDR_W-1:0] wptr, rptr;
    logic [CW-1:0]     mem_cnt, mem_cnt_nxt, occ;
    logic [DATA_W-1:0] head_q, head_d;
    logic              head_v;
    logic              is_fwft, mem_nz, acc_wr, acc_rd;
    logic              push, pop;

    assign is_fwft = (mode == RD_FWFT);
    assign occ     = mem_cnt + CW'(head_v);
    assign mem_nz  = (mem_cnt != '0);
    assign acc_wr  = wr_en && (occ != DEPTH_V);
    assign acc_rd  = is_fwft ? (rd_en && head_v) : (rd_en && mem_nz);

    // Route accepted accesses: memory push/pop and head-register refill
    always_comb begin
        push       = acc_wr;
        pop        = 1'b0;
        head_d     = head_q;
        head_v_nxt = head_v;
        if (is_fwft) begin
            if (!head_v || acc_rd) begin
                if (mem_nz) begin
                    pop        = 1'b1;
                    head_d     = mem_rdata;
                    head_v_nxt = 1'b1;
                end else if (acc_wr) begin
                    push       = 1'b0;
                    head_d     = wr_data;
                    head_v_nxt = 1'b1;
                end else begin
                    head_v_nxt = 1'b0;
                end
            end
        end else begin
            head_v_nxt = 1'b0;
            if (acc_rd) begin
                pop    = 1'b1;
                head_d = mem_rdata;
            end
        end
    end

    assign mem_cnt_nxt = mem_cnt + CW'(push) - CW'(pop);
    assign occ_nxt     = mem_cnt_nxt + CW'(head_v_nxt);
    assign mem_we      = push;
    assign mem_waddr   = wptr;
    assign mem_raddr   = rptr;
    assign rd_data     = head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            mem_cnt <= '0;
            head_v  <= 1'b0;
            head_q  <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            mem_cnt <= mem_cnt_nxt;
            head_v  <= head_v_nxt;
            head_q  <= head_d;
        end
    end

    // R4: memory count never exceeds the depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        mem_cnt <= DEPTH_V);

    // R4: a write into a full buffer without a read leaves the write pointer alone
    a_r4_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && occ == DEPTH_V) |=> $stable(wptr));

    // R5: a standard read of an empty buffer leaves the read pointer alone
    a_r5_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
        (!is_fwft && rd_en && mem_cnt == '0) |=> $stable(rptr));

    // R6: accepted read plus accepted write keeps the occupancy
    a_r6_simul_keeps_occ: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && acc_wr) |=> (occ == $past(occ)));

    // R3: a write into an empty fall-through buffer makes the head valid next cycle
    a_r3_fwft_ready_after_write: assert property (@(posedge clk) disable iff (rst)
        (is_fwft && wr_en && occ == '0) |=> head_v);

endmodule

// File: rtl/pflag_fifo_flags.sv
module pflag_fifo_flags
    import pflag_fifo_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  rd_mode_e        mode,
    input  logic            cfg_we,
    input  ofs_sel_e        cfg_sel,
    input  logic [ADDR_W:0] cfg_data,
    input  logic [ADDR_W:0] occ_nxt,
    input  logic            head_v_nxt,
    output flag_t           flags
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned OW    = ADDR_W + 1;
    localparam logic [OW-1:0] OFS_RST = OW'(DEF_OFFSET);

    logic [OW-1:0] m_q, n_q, m_nxt, n_nxt;

    always_comb begin
        m_nxt = m_q;
        n_nxt = n_q;
        if (cfg_we) begin
            if (cfg_sel == OFS_FULL) m_nxt = cfg_data;
            else                     n_nxt = cfg_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q   <= OFS_RST;
            n_q   <= OFS_RST;
            flags <= flags_from(0, DEPTH, 32'(OFS_RST), 32'(OFS_RST),
                                mode == RD_FWFT, 1'b0);
        end else begin
            m_q   <= m_nxt;
            n_q   <= n_nxt;
            flags <= flags_from(32'(occ_nxt), DEPTH, 32'(m_nxt), 32'(n_nxt),
                                mode == RD_FWFT, head_v_nxt);
        end
    end

    // R10: a full-offset write lands in m
    a_r10_full_ofs_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == OFS_FULL) |=> (m_q == $past(cfg_data)));

    // R10: an empty-offset write lands in n
    a_r10_empty_ofs_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == OFS_EMPTY) |=> (n_q == $past(cfg_data)));

endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
    import pflag_fifo_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W:0]   cfg_data,
    output logic              full,
    output logic              head_flag,
    output logic              af_n,
    output logic              ae_n,
    output logic              hf_n
);
    rd_mode_e          mode;
    ofs_sel_e          sel;
    flag_t             flags;
    logic              mem_we, head_v_nxt;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [ADDR_W:0]   occ_nxt;

    assign mode = rd_mode_e'(rd_mode);
    assign sel  = ofs_sel_e'(cfg_sel);

    pflag_fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    pflag_fifo_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .mem_rdata  (mem_rdata),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_raddr  (mem_raddr),
        .rd_data    (rd_data),
        .occ_nxt    (occ_nxt),
        .head_v_nxt (head_v_nxt)
    );

    pflag_fifo_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .cfg_we     (cfg_we),
        .cfg_sel    (sel),
        .cfg_data   (cfg_data),
        .occ_nxt    (occ_nxt),
        .head_v_nxt (head_v_nxt),
        .flags      (flags)
    );

    assign full      = flags.full;
    assign head_flag = flags.head;
    assign af_n      = flags.af_n;
    assign ae_n      = flags.ae_n;
    assign hf_n      = flags.hf_n;

    // R9: a full buffer is past half
    a_r9_hf_when_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !hf_n);

    // R7: no free space is never above any offset
    a_r7_af_when_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !af_n);

endmodule

// File: tb/pflag_fifo_test.sv
`timescale 1ns/1ps
module pflag_fifo_test;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst, rd_mode, wr_en, rd_en, cfg_we, cfg_sel;
    logic [DW-1:0] wr_data, rd_data;
    logic [AW:0]   cfg_data;
    logic          full, head_flag, af_n, ae_n, hf_n;

    int checks = 0;
    int fails  = 0;
    int q[$];
    int mm, nn;
    int last_rd;
    bit fw;
    bit done = 0;

    always #2.5 clk = ~clk;

    pflag_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .rd_mode(rd_mode), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .full(full), .head_flag(head_flag), .af_n(af_n),
        .ae_n(ae_n), .hf_n(hf_n)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(bit f);
        @(negedge clk);
        rst = 1; rd_mode = f; wr_en = 0; rd_en = 0; cfg_we = 0;
        cfg_sel = 0; cfg_data = '0; wr_data = '0;
        repeat (2) @(negedge clk);
        rst = 0;
        q.delete(); mm = 7; nn = 7; fw = f; last_rd = 0;
    endtask

    task automatic op(bit w, int d, bit r);
        int sz = q.size();
        bit aw = w && (sz < DEPTH);
        bit ar = r && (sz > 0);
        wr_en = w; wr_data = DW'(d); rd_en = r;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        if (ar) last_rd = q.pop_front();
        if (aw) q.push_back(d);
    endtask

    task automatic cfg(bit sel, int v);
        cfg_we = 1; cfg_sel = sel; cfg_data = (AW+1)'(v);
        @(negedge clk);
        cfg_we = 0;
        if (sel) mm = v; else nn = v;
    endtask

    task automatic chk_flags();
        int c = q.size();
        chk("R4 full", full, c == DEPTH);
        if (fw) begin
            chk("R3 head_flag", head_flag, c > 0);
            if (c > 0) chk("R3 rd_data", rd_data, q[0]);
        end else begin
            chk("R2 head_flag", head_flag, c == 0);
            chk("R1 rd_data", rd_data, last_rd);
        end
        chk("R7 af_n", af_n, (DEPTH - c) > mm);
        chk("R8 ae_n", ae_n, c >= nn);
        chk("R9 hf_n", hf_n, !(c >= DEPTH/2 + 1));
    endtask

    task automatic t_reset_state();
        do_reset(0);
        chk("R11 head_flag std", head_flag, 1);
        chk("R11 af_n", af_n, 1);
        chk("R11 ae_n", ae_n, 0);
        chk("R11 hf_n", hf_n, 1);
        chk("R11 full", full, 0);
        chk_flags();
    endtask

    task automatic t_std_fill_drain();
        do_reset(0);
        for (int i = 0; i < DEPTH; i++) begin op(1, 'h100 + i, 0); chk_flags(); end
        op(1, 'hDEAD, 0); chk_flags();               // R4 write when full
        for (int i = 0; i < DEPTH; i++) begin op(0, 0, 1); chk_flags(); end
        chk("R1 last word", rd_data, 'h10F);
        op(0, 0, 1); chk_flags();                    // R5 read when empty
        chk("R5 data held", rd_data, 'h10F);
        op(1, 'h55, 0); op(0, 0, 1); chk_flags();
        chk("R5 pointer intact", rd_data, 'h55);
    endtask

    task automatic t_std_simul();
        do_reset(0);
        op(1, 'h7, 1); chk_flags();                  // read refused, write taken
        for (int i = 0; i < 4; i++) begin op(1, 'h20 + i, 0); chk_flags(); end
        for (int i = 0; i < 3; i++) begin
            op(1, 'h30 + i, 1); chk_flags();
            chk("R6 occupancy", q.size(), 5);
        end
        for (int i = 0; i < 5; i++) begin op(0, 0, 1); chk_flags(); end
    endtask

    task automatic t_offsets();
        do_reset(0);
        cfg(0, 3); chk_flags();
        chk("R10 ae_n after n write", ae_n, 0);
        cfg(1, 2); chk_flags();
        for (int i = 0; i < DEPTH; i++) begin op(1, 'h200 + i, 0); chk_flags(); end
        cfg(1, 0); chk_flags();
        chk("R10 af_n with m=0 when full", af_n, 0);
        cfg(0, 16); chk_flags();
        for (int i = 0; i < DEPTH; i++) begin op(0, 0, 1); chk_flags(); end
    endtask

    task automatic t_fwft();
        do_reset(1);
        chk("R11 head_flag fwft", head_flag, 0);
        op(1, 'hA1, 0);
        chk("R3 ready after write", head_flag, 1);
        chk("R3 head word", rd_data, 'hA1);
        chk_flags();
        op(1, 'hB2, 1); chk_flags();                 // R6 bypass on one word
        chk("R6 handover", rd_data, 'hB2);
        op(0, 0, 1); chk_flags();
        op(0, 0, 1); chk_flags();                    // R5 read while not ready
        for (int i = 0; i < DEPTH; i++) begin op(1, 'h300 + i, 0); chk_flags(); end
        op(1, 'hBEEF, 0); chk_flags();               // R4 full in fwft
        op(1, 'hC0, 1); chk_flags();
        for (int i = 0; i < DEPTH; i++) begin op(0, 0, 1); chk_flags(); end
    endtask

    initial begin
        t_reset_state();
        t_std_fill_drain();
        t_std_simul();
        t_offsets();
        t_fwft();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule